// File: doc/BRIEF.md
# Host-Programmed Serial Bus Command Channel

This block gives a host processor a small register window for starting single register transactions on a serial power-management bus. Each transaction addresses one of sixteen slave IDs and carries one to four data bytes. The host describes the whole transaction in one 32-bit command word. For a write, the host first places the outgoing bytes in a data register, then writes the command word. A three-bit state field in the status register tracks the transfer while it runs.

The serial bus itself is not part of the block. A request/response back-end port stands in for it. One request pulse goes out for each accepted command, and the request fields stay stable until the transaction ends. The back-end answers with a single response pulse after any latency it chooses.

A completed read does not release the channel on its own. The returned bytes are held, and the state waits until the host acknowledges them by writing 1 to a valid-clear register. The same register also lets a host that timed out bring the channel back to idle.

Top module: `sercmd_channel`

## Requirements
- R1: After reset the status register reads 0 (state idle, no error), the read-data register reads 0, and `bus_req_valid` is low.
- R2: A write to the command offset (0x00) while the state is idle has these effects. On the next cycle, `bus_req_valid` is high for exactly one cycle and the status state field (bits [3:1]) reads 1 (busy). The request fields are taken from the command word: class from bits [31:30], write flag from bit 29, slave ID from bits [27:24], byte count minus one from bits [18:16], register address from bits [15:0].
- R3: The write-data register (offset 0x04) reads back what the host last wrote to it. The request data is a copy taken at the moment the command is accepted. Writes to 0x04 during the transaction do not change `bus_req_wdata`.
- R4: In the busy state with a write in progress, a `bus_resp_valid` pulse returns the state to idle (0) on the next cycle.
- R5: In the busy state with a read in progress, a `bus_resp_valid` pulse moves the state to wait-for-clear (6) on the next cycle. The read-data register (offset 0x14) then holds the response word. Bytes above the requested count read as zero, little-endian (byte 0 in bits [7:0]). A count field above 3 is treated as four bytes, and `bus_req_len` then reads 3.
- R6: In wait-for-clear, a write to the valid-clear offset (0x24) with bit 0 set returns the state to idle, and the read-data register keeps its value. A write with bit 0 clear leaves the state in wait-for-clear.
- R7: A write to valid-clear while the state is idle or busy has no effect on the state.
- R8: A command written while the state is not idle is ignored. No request pulse follows, and the request fields keep their values. Status bit 0 is set and stays set until reset.
- R9: Offsets other than 0x04, 0x14 and 0x28 read as 0, including the command and valid-clear offsets. Writes to offsets other than 0x00, 0x04 and 0x24 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| bus_req_valid | output | 1 | One-cycle request pulse to the back-end |
| bus_req_write | output | 1 | Request is a write |
| bus_req_class | output | 2 | Command class |
| bus_req_sid | output | 4 | Slave ID |
| bus_req_len | output | 2 | Byte count minus one, clamped to 3 |
| bus_req_addr | output | 16 | Slave register address |
| bus_req_wdata | output | 32 | Captured write data, unused bytes zero |
| bus_resp_valid | input | 1 | Back-end completion pulse |
| bus_resp_rdata | input | 32 | Back-end read data |

## Verification
The assertions assume that the back-end raises `bus_resp_valid` only while the channel is busy, at least one cycle after the request pulse, and only once per request. They also assume that the host never writes two offsets in the same cycle, which the single write port already guarantees. The bench's back-end model loads its countdown only from a seen request pulse, and the countdown is always at least one cycle, so a response can never precede or repeat a request. The stimulus that writes to the channel while it is busy therefore exercises the host side only and never produces a stray response.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_WDAT = 6'h04;
    localparam logic [OFS_W-1:0] OFS_RDAT = 6'h14;
    localparam logic [OFS_W-1:0] OFS_VCLR = 6'h24;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h28;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BUSY = 3'd1,
        ST_WCLR = 3'd6
    } chan_state_e;

    typedef struct packed {
        logic [1:0]  cls;
        logic        wr;
        logic [3:0]  sid;
        logic [1:0]  len_m1;
        logic [15:0] addr;
    } bus_req_t;

    // count field values above 3 mean four bytes
    function automatic logic [1:0] clamp_len(input logic [2:0] cnt);
        return (cnt > 3'd3) ? 2'd3 : cnt[1:0];
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] len_m1);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < WORD_W / 8; b++)
            m[b*8 +: 8] = (b <= int'(len_m1)) ? 8'hFF : 8'h00;
        return m;
    endfunction

endpackage

// File: rtl/sercmd_regdec.sv
module sercmd_regdec
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdat_q,
    input  logic [WORD_W-1:0] rdat_q,
    input  logic [WORD_W-1:0] stat_word,
    output logic              wr_cmd,
    output logic              wr_wdat,
    output logic              wr_vclr,
    output logic [WORD_W-1:0] rd_data
);

    always_comb begin
        wr_cmd  = wr_en && (addr == ADDR_W'(OFS_CMD));
        wr_wdat = wr_en && (addr == ADDR_W'(OFS_WDAT));
        wr_vclr = wr_en && (addr == ADDR_W'(OFS_VCLR));
    end

    always_comb begin
        if (addr == ADDR_W'(OFS_WDAT))
            rd_data = wdat_q;
        else if (addr == ADDR_W'(OFS_RDAT))
            rd_data = rdat_q;
        else if (addr == ADDR_W'(OFS_STAT))
            rd_data = stat_word;
        else
            rd_data = '0;
    end

endmodule

// File: rtl/sercmd_engine.sv
module sercmd_engine
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_wdat,
    input  logic              wr_vclr,
    input  logic [WORD_W-1:0] wdata_in,
    input  logic              resp_valid,
    input  logic [WORD_W-1:0] resp_rdata,
    output chan_state_e       state,
    output logic              err,
    output logic [WORD_W-1:0] wdat_q,
    output logic [WORD_W-1:0] rdat_q,
    output bus_req_t          req,
    output logic [WORD_W-1:0] req_wdata,
    output logic              req_valid
);

    bus_req_t dec;

    // unpack an incoming command word
    always_comb begin
        dec.cls    = wdata_in[31:30];
        dec.wr     = wdata_in[29];
        dec.sid    = wdata_in[27:24];
        dec.len_m1 = clamp_len(wdata_in[18:16]);
        dec.addr   = wdata_in[15:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            err       <= 1'b0;
            wdat_q    <= '0;
            rdat_q    <= '0;
            req       <= '0;
            req_wdata <= '0;
            req_valid <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            if (wr_wdat)
                wdat_q <= wdata_in;
            unique case (state)
                ST_IDLE: begin
                    if (wr_cmd) begin
                        req       <= dec;
                        req_wdata <= wdat_q & lane_mask(dec.len_m1);
                        req_valid <= 1'b1;
                        state     <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (wr_cmd)
                        err <= 1'b1;
                    if (resp_valid) begin
                        if (req.wr) begin
                            state <= ST_IDLE;
                        end else begin
                            rdat_q <= resp_rdata & lane_mask(req.len_m1);
                            state  <= ST_WCLR;
                        end
                    end
                end
                ST_WCLR: begin
                    if (wr_cmd)
                        err <= 1'b1;
                    if (wr_vclr && wdata_in[0])
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sercmd_channel.sv
module sercmd_channel
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [1:0]        bus_req_class,
    output logic [3:0]        bus_req_sid,
    output logic [1:0]        bus_req_len,
    output logic [15:0]       bus_req_addr,
    output logic [31:0]       bus_req_wdata,
    input  logic              bus_resp_valid,
    input  logic [31:0]       bus_resp_rdata
);

    logic              wr_cmd, wr_wdat, wr_vclr;
    chan_state_e       chan_state;
    logic              chan_err;
    logic [WORD_W-1:0] wdat_q, rdat_q, stat_word;
    bus_req_t          req;

    assign stat_word = {{(WORD_W-4){1'b0}}, chan_state, chan_err};

    sercmd_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en     (host_wr_en),
        .addr      (host_addr),
        .wdat_q    (wdat_q),
        .rdat_q    (rdat_q),
        .stat_word (stat_word),
        .wr_cmd    (wr_cmd),
        .wr_wdat   (wr_wdat),
        .wr_vclr   (wr_vclr),
        .rd_data   (host_rdata)
    );

    sercmd_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .wr_cmd     (wr_cmd),
        .wr_wdat    (wr_wdat),
        .wr_vclr    (wr_vclr),
        .wdata_in   (host_wdata),
        .resp_valid (bus_resp_valid),
        .resp_rdata (bus_resp_rdata),
        .state      (chan_state),
        .err        (chan_err),
        .wdat_q     (wdat_q),
        .rdat_q     (rdat_q),
        .req        (req),
        .req_wdata  (bus_req_wdata),
        .req_valid  (bus_req_valid)
    );

    assign bus_req_write = req.wr;
    assign bus_req_class = req.cls;
    assign bus_req_sid   = req.sid;
    assign bus_req_len   = req.len_m1;
    assign bus_req_addr  = req.addr;

endmodule

// File: rtl/sercmd_channel_chk.sv
module sercmd_channel_chk
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic              vclr_bit,
    input logic              bus_req_valid,
    input logic              bus_req_write,
    input logic [31:0]       bus_req_wdata,
    input logic              bus_resp_valid,
    input logic [2:0]        st,
    input logic              err
);

    logic cmd_wr, vclr_wr;
    assign cmd_wr  = host_wr_en && (host_addr == ADDR_W'(OFS_CMD));
    assign vclr_wr = host_wr_en && (host_addr == ADDR_W'(OFS_VCLR));

    always_comb begin
        if (!rst)
            assert_legal_state_R2: assert (st == 3'd0 || st == 3'd1 || st == 3'd6);
    end

    assert_cmd_issues_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && st == 3'd0) |=> (bus_req_valid && st == 3'd1));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |=> !bus_req_valid);

    assert_snapshot_held_R3: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd1 && !bus_req_valid) |=> (st != 3'd1 || $stable(bus_req_wdata)));

    assert_write_done_R4: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd1 && bus_resp_valid && bus_req_write) |=> st == 3'd0);

    assert_read_done_R5: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd1 && bus_resp_valid && !bus_req_write) |=> st == 3'd6);

    assert_vclr_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd6 && vclr_wr && vclr_bit) |=> st == 3'd0);

    assert_vclr_busy_noop_R7: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd1 && vclr_wr && !bus_resp_valid) |=> st == 3'd1);

    assert_vclr_idle_noop_R7: assert property (@(posedge clk) disable iff (rst)
        (st == 3'd0 && vclr_wr) |=> st == 3'd0);

    assert_cmd_rejected_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && st != 3'd0) |=> (!bus_req_valid && err));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_resp_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        bus_resp_valid |-> st == 3'd1);

endmodule

bind sercmd_channel sercmd_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_wr_en     (host_wr_en),
    .host_addr      (host_addr),
    .vclr_bit       (host_wdata[0]),
    .bus_req_valid  (bus_req_valid),
    .bus_req_write  (bus_req_write),
    .bus_req_wdata  (bus_req_wdata),
    .bus_resp_valid (bus_resp_valid),
    .st             (chan_state),
    .err            (chan_err)
);

// File: tb/sim_sercmd_channel.sv
module sim_sercmd_channel;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          bus_req_valid, bus_req_write;
    logic [1:0]    bus_req_class, bus_req_len;
    logic [3:0]    bus_req_sid;
    logic [15:0]   bus_req_addr;
    logic [31:0]   bus_req_wdata;
    logic          bus_resp_valid = 1'b0;
    logic [31:0]   bus_resp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int lat = 2;
    int countdown = 0;
    logic [31:0] resp_word = '0;

    always #2 clk = ~clk;

    sercmd_channel #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_class(bus_req_class), .bus_req_sid(bus_req_sid),
        .bus_req_len(bus_req_len), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata),
        .bus_resp_valid(bus_resp_valid), .bus_resp_rdata(bus_resp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_mask(input int cnt);
        int nb = (cnt > 3) ? 4 : cnt + 1;
        return (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
    endfunction

    function automatic logic [31:0] stat_of(input int st, input bit e);
        return {28'd0, st[2:0], e};
    endfunction

    function automatic logic [31:0] cmd_of(input bit wr, input logic [1:0] cls,
                                           input logic [3:0] sid, input logic [2:0] cnt,
                                           input logic [15:0] a);
        return {cls, wr, 1'b0, sid, 5'd0, cnt, a};
    endfunction

    // back-end model: responds lat cycles after each request pulse
    initial begin
        forever begin
            @(negedge clk);
            bus_resp_valid = 1'b0;
            if (countdown > 0) begin
                countdown--;
                if (countdown == 0) begin
                    bus_resp_valid = 1'b1;
                    bus_resp_rdata = resp_word;
                end
            end
            if (bus_req_valid) begin
                countdown = lat;
                resp_word = $urandom;
            end
        end
    end

    task automatic host_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [5:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_settle();
        logic [31:0] d;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            host_rd(6'h28, d);
            if (d[3:1] != 3'd1) break;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        countdown = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    bit exp_err = 0;

    task automatic run_txn(input bit wr, input logic [1:0] cls, input logic [3:0] sid,
                           input logic [2:0] cnt, input logic [15:0] a,
                           input logic [31:0] wd);
        logic [31:0] d;
        logic [31:0] m;
        m = exp_mask(int'(cnt));
        host_wr(6'h04, wd);
        host_wr(6'h00, cmd_of(wr, cls, sid, cnt, a));
        chk("R2 req pulse", {31'd0, bus_req_valid}, 32'd1);
        chk("R2 req fields",
            {7'd0, bus_req_write, bus_req_class, bus_req_sid, bus_req_len, bus_req_addr},
            {7'd0, wr, cls, sid, (cnt > 3'd3) ? 2'd3 : cnt[1:0], a});
        chk("R3 req wdata", bus_req_wdata, wd & m);
        host_rd(6'h28, d);
        chk("R2 busy status", d, stat_of(1, exp_err));
        wait_settle();
        host_rd(6'h28, d);
        if (wr) begin
            chk("R4 write back to idle", d, stat_of(0, exp_err));
        end else begin
            chk("R5 wait-for-clear", d, stat_of(6, exp_err));
            host_rd(6'h14, d);
            chk("R5 masked read data", d, resp_word & m);
            host_wr(6'h24, 32'd1);
            host_rd(6'h28, d);
            chk("R6 clear to idle", d, stat_of(0, exp_err));
            host_rd(6'h14, d);
            chk("R6 read data kept", d, resp_word & m);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        void'($urandom(32'd1234));
        do_reset();

        // R1 reset state
        host_rd(6'h28, d); chk("R1 status", d, 32'd0);
        host_rd(6'h14, d); chk("R1 read data", d, 32'd0);
        chk("R1 no request", {31'd0, bus_req_valid}, 32'd0);

        // R3 / R9 write-data readback
        host_wr(6'h04, 32'hA5A5_1234);
        host_rd(6'h04, d); chk("R3 wdata readback", d, 32'hA5A5_1234);

        // R9 unmapped and write-only offsets
        host_rd(6'h00, d); chk("R9 cmd reads zero", d, 32'd0);
        host_rd(6'h24, d); chk("R9 vclr reads zero", d, 32'd0);
        host_rd(6'h08, d); chk("R9 hole reads zero", d, 32'd0);
        host_wr(6'h14, 32'hFFFF_FFFF);
        host_wr(6'h28, 32'hFFFF_FFFF);
        host_wr(6'h3C, 32'hFFFF_FFFF);
        host_rd(6'h14, d); chk("R9 rdata not writable", d, 32'd0);
        host_rd(6'h28, d); chk("R9 status not writable", d, 32'd0);

        // R7 valid-clear in idle
        host_wr(6'h24, 32'd1);
        host_rd(6'h28, d); chk("R7 vclr idle no effect", d, 32'd0);

        // directed transactions
        lat = 1;
        run_txn(1'b1, 2'd1, 4'd3, 3'd0, 16'h0042, 32'hDEAD_BEEF);
        run_txn(1'b0, 2'd3, 4'd15, 3'd1, 16'hFFFF, 32'h0);
        run_txn(1'b0, 2'd2, 4'd0, 3'd7, 16'h1000, 32'h0);   // R5 clamp to 4 bytes
        run_txn(1'b1, 2'd0, 4'd9, 3'd2, 16'h0001, 32'h1122_3344);

        // R6 valid-clear with bit0 clear is not an acknowledge
        lat = 3;
        host_wr(6'h00, cmd_of(1'b0, 2'd1, 4'd5, 3'd3, 16'h0010));
        wait_settle();
        host_wr(6'h24, 32'd2);
        host_rd(6'h28, d); chk("R6 vclr bit0 clear ignored", d, stat_of(6, 0));
        host_wr(6'h24, 32'd1);
        host_rd(6'h28, d); chk("R6 vclr releases", d, stat_of(0, 0));

        // R3 snapshot held while busy, R7 vclr in busy, R8 cmd in busy
        lat = 20;
        host_wr(6'h04, 32'hCAFE_0001);
        host_wr(6'h00, cmd_of(1'b0, 2'd2, 4'd6, 3'd3, 16'h0ABC));
        held = bus_req_wdata;
        host_wr(6'h04, 32'h5555_AAAA);
        chk("R3 snapshot unchanged", bus_req_wdata, held);
        host_rd(6'h04, d); chk("R3 new wdata visible", d, 32'h5555_AAAA);
        host_wr(6'h24, 32'd1);
        host_rd(6'h28, d); chk("R7 vclr busy no effect", d, stat_of(1, 0));
        host_wr(6'h00, cmd_of(1'b1, 2'd0, 4'd1, 3'd0, 16'h0001));
        chk("R8 no pulse when busy", {31'd0, bus_req_valid}, 32'd0);
        chk("R8 fields kept", {16'd0, bus_req_sid, 10'd0, bus_req_len}, {16'd0, 4'd6, 10'd0, 2'd3});
        host_rd(6'h28, d); chk("R8 error flag", d, stat_of(1, 1));
        wait_settle();
        host_wr(6'h00, cmd_of(1'b1, 2'd0, 4'd2, 3'd0, 16'h0002));
        chk("R8 no pulse in wait-for-clear", {31'd0, bus_req_valid}, 32'd0);
        host_rd(6'h28, d); chk("R8 stays wait-for-clear", d, stat_of(6, 1));
        host_wr(6'h24, 32'd1);
        host_rd(6'h28, d); chk("R8 error sticky after idle", d, stat_of(0, 1));
        do_reset();
        host_rd(6'h28, d); chk("R1 error cleared by reset", d, 32'd0);

        // random transactions
        for (int i = 0; i < 40; i++) begin
            lat = 1 + int'($urandom % 6);
            run_txn(1'($urandom), 2'($urandom), 4'($urandom), 3'($urandom),
                    16'($urandom), $urandom);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule